// File: doc/BRIEF.md
# Channel-Indexed Configuration Register Bank

This block is the byte-wide configuration store of a two-channel data converter. A host reaches it through a plain parallel register port made of an address, write data, a write strobe, a read strobe and registered read data. Some settings exist once for the whole part; these are the shared registers. Other settings are kept separately for each channel; these are the per-channel registers, and they are duplicated in hardware. A channel-select register holds a bit mask that decides which channel copies a per-channel access reaches.

Setting both mask bits lets a single write program both channels at once. A read with both bits set returns the channel A copy. Every register comes out of reset with a fixed default. Bits that are not implemented read as zero. Addresses with no register behind them are ignored and flagged. All register contents are driven out as flat vectors so that the converter datapath can use them directly.

Top module: `cfg_bank`

## Requirements
- R1: After reset the shared registers hold their defaults: 0x000=0x18, 0x001=0x00, 0x002=0x05, 0x014=0x01, 0x100=0x02. Both copies of each per-channel register hold their defaults: 0x008=0x00, 0x00D=0x00, 0x102=0x80. rdata_o and bad_addr_o are 0.
- R2: The channel-select register sits at address 0x005. Only bits [1:0] are implemented, bit 0 selecting channel A and bit 1 selecting channel B. It resets to 0x03, reads back with bits [7:2] as 0, and is driven on chsel_o.
- R3: A write to a per-channel register updates the channel A copy when bit 0 is set and the channel B copy when bit 1 is set. With both bits set, both copies take the same value in the same cycle.
- R4: A read of a per-channel register returns the channel A copy whenever bit 0 is set, including when both bits are set. It returns the channel B copy when only bit 1 is set.
- R5: With the channel-select register at 0, writes to per-channel registers change nothing and reads of them return 0x00.
- R6: A write to a shared register takes effect whatever the channel-select value.
- R7: The implemented-bit masks are 0x000:0x7E, 0x001:0xFF, 0x002:0x0F, 0x014:0xFF, 0x100:0x07, 0x008:0xE3, 0x00D:0x3F and 0x102:0xFF. Bits outside a mask read as 0, and writes to them have no effect.
- R8: An access to any other address changes no register and reads as 0x00. It raises bad_addr_o for exactly the one cycle after the access.
- R9: A write is visible on the output vectors right after the clock edge where wr_i is high. rdata_o is loaded on the edge where rd_i is high and holds its value while rd_i is low.
- R10: If rd_i and wr_i are high together at the same address, rdata_o returns the value that was there before the write.
- R11: Output layout: slot g of glob_o is bits [8g+7:8g], with slots ordered 0x000, 0x001, 0x002, 0x014, 0x100. Slot l of channel c in loc_o is bits [8(3c+l)+7:8(3c+l)], with slots ordered 0x008, 0x00D, 0x102 and channel A as c=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 9 | Register address |
| wdata_i | input | 8 | Write data |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| rdata_o | output | 8 | Registered read data |
| bad_addr_o | output | 1 | One-cycle pulse after an access to an undefined address |
| chsel_o | output | 2 | Channel-select mask |
| glob_o | output | 40 | Shared register contents |
| loc_o | output | 48 | Per-channel register contents, channel A first |

## Verification
A wrong channel-select bit sends the next per-channel write to the wrong copy. That error appears on loc_o on the clock edge after that write, and in rdata_o one cycle after the next read. A bad mask or default shows on glob_o or loc_o from the first cycle after reset. A faulty address decode shows either as a bad_addr_o pulse one cycle after a legal access, or as a register vector that changes after an illegal write. Because every output vector is compared after each access, any corrupted state is caught at most one access after it occurs.

// File: rtl/cfg_bank_pkg.sv
package cfg_bank_pkg;
  localparam int ADDR_W = 9;
  localparam int DATA_W = 8;
  localparam int NUM_CH = 2;
  localparam int NUM_G  = 5;
  localparam int NUM_L  = 3;

  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [DATA_W-1:0] byte_t;

  localparam addr_t IDX_ADDR = 9'h005;

  localparam addr_t G_ADDR [NUM_G] = '{9'h000, 9'h001, 9'h002, 9'h014, 9'h100};
  localparam byte_t G_MASK [NUM_G] = '{8'h7E, 8'hFF, 8'h0F, 8'hFF, 8'h07};
  localparam byte_t G_DEF  [NUM_G] = '{8'h18, 8'h00, 8'h05, 8'h01, 8'h02};

  localparam addr_t L_ADDR [NUM_L] = '{9'h008, 9'h00D, 9'h102};
  localparam byte_t L_MASK [NUM_L] = '{8'hE3, 8'h3F, 8'hFF};
  localparam byte_t L_DEF  [NUM_L] = '{8'h00, 8'h00, 8'h80};

  function automatic logic addr_valid(addr_t a);
    logic v;
    v = (a == IDX_ADDR);
    for (int i = 0; i < NUM_G; i++) if (a == G_ADDR[i]) v = 1'b1;
    for (int i = 0; i < NUM_L; i++) if (a == L_ADDR[i]) v = 1'b1;
    return v;
  endfunction
endpackage

// File: rtl/cfg_bank_dec.sv
module cfg_bank_dec
  import cfg_bank_pkg::*;
(
  input  addr_t            addr_i,
  output logic [NUM_G-1:0] g_hit_o,
  output logic [NUM_L-1:0] l_hit_o,
  output logic             idx_hit_o,
  output logic             valid_o
);
  for (genvar i = 0; i < NUM_G; i++) begin : g_gdec
    assign g_hit_o[i] = (addr_i == G_ADDR[i]);
  end
  for (genvar i = 0; i < NUM_L; i++) begin : g_ldec
    assign l_hit_o[i] = (addr_i == L_ADDR[i]);
  end
  assign idx_hit_o = (addr_i == IDX_ADDR);
  assign valid_o   = idx_hit_o | (|g_hit_o) | (|l_hit_o);
endmodule

// File: rtl/cfg_bank_reg.sv
module cfg_bank_reg #(
  parameter int              W    = 8,
  parameter logic [W-1:0]    MASK = '1,
  parameter logic [W-1:0]    DEF  = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= DEF & MASK;
    else if (we_i) q_o <= d_i & MASK;
  end
endmodule

// File: rtl/cfg_bank.sv
module cfg_bank
  import cfg_bank_pkg::*;
(
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [ADDR_W-1:0]             addr_i,
  input  logic [DATA_W-1:0]             wdata_i,
  input  logic                          wr_i,
  input  logic                          rd_i,
  output logic [DATA_W-1:0]             rdata_o,
  output logic                          bad_addr_o,
  output logic [NUM_CH-1:0]             chsel_o,
  output logic [NUM_G*DATA_W-1:0]       glob_o,
  output logic [NUM_CH*NUM_L*DATA_W-1:0] loc_o
);
  logic [NUM_G-1:0] g_hit;
  logic [NUM_L-1:0] l_hit;
  logic             idx_hit, valid;
  logic [NUM_CH-1:0] chsel_q;
  byte_t            glob_q [NUM_G];
  byte_t            loc_q  [NUM_CH][NUM_L];
  byte_t            rd_mux;

  cfg_bank_dec u_dec (
    .addr_i   (addr_i),
    .g_hit_o  (g_hit),
    .l_hit_o  (l_hit),
    .idx_hit_o(idx_hit),
    .valid_o  (valid)
  );

  cfg_bank_reg #(.W(NUM_CH), .MASK('1), .DEF('1)) u_chsel (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .we_i  (wr_i & idx_hit),
    .d_i   (wdata_i[NUM_CH-1:0]),
    .q_o   (chsel_q)
  );

  for (genvar g = 0; g < NUM_G; g++) begin : g_glob
    cfg_bank_reg #(.W(DATA_W), .MASK(G_MASK[g]), .DEF(G_DEF[g])) u_reg (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .we_i  (wr_i & g_hit[g]),
      .d_i   (wdata_i),
      .q_o   (glob_q[g])
    );
    assign glob_o[g*DATA_W +: DATA_W] = glob_q[g];
  end

  // per-channel copies: write fans out to every selected channel
  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    for (genvar l = 0; l < NUM_L; l++) begin : g_loc
      cfg_bank_reg #(.W(DATA_W), .MASK(L_MASK[l]), .DEF(L_DEF[l])) u_reg (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .we_i  (wr_i & l_hit[l] & chsel_q[c]),
        .d_i   (wdata_i),
        .q_o   (loc_q[c][l])
      );
      assign loc_o[(c*NUM_L+l)*DATA_W +: DATA_W] = loc_q[c][l];
    end
  end

  // lowest selected channel wins on read
  always_comb begin
    rd_mux = '0;
    if (idx_hit) rd_mux = {{(DATA_W-NUM_CH){1'b0}}, chsel_q};
    for (int g = 0; g < NUM_G; g++)
      if (g_hit[g]) rd_mux = glob_q[g];
    for (int l = 0; l < NUM_L; l++)
      if (l_hit[l])
        for (int c = NUM_CH-1; c >= 0; c--)
          if (chsel_q[c]) rd_mux = loc_q[c][l];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o    <= '0;
      bad_addr_o <= 1'b0;
    end else begin
      if (rd_i) rdata_o <= rd_mux;
      bad_addr_o <= (wr_i | rd_i) & ~valid;
    end
  end

  assign chsel_o = chsel_q;
endmodule

// File: rtl/cfg_bank_chk.sv
module cfg_bank_chk
  import cfg_bank_pkg::*;
(
  input logic                           clk_i,
  input logic                           rst_ni,
  input logic [ADDR_W-1:0]              addr_i,
  input logic [DATA_W-1:0]              wdata_i,
  input logic                           wr_i,
  input logic                           rd_i,
  input logic [DATA_W-1:0]              rdata_o,
  input logic                           bad_addr_o,
  input logic [NUM_CH-1:0]              chsel_o,
  input logic [NUM_G*DATA_W-1:0]        glob_o,
  input logic [NUM_CH*NUM_L*DATA_W-1:0] loc_o
);
  AST_IDLE_NO_BAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_i || rd_i) |=> !bad_addr_o); // R8

  AST_BAD_RD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !addr_valid(addr_i)) |=> (rdata_o == '0) && bad_addr_o); // R8

  AST_BAD_WR_NOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !addr_valid(addr_i)) |=> $stable(glob_o) && $stable(loc_o) && $stable(chsel_o)); // R8

  AST_RD_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> $stable(rdata_o)); // R9

  AST_NO_WR_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> $stable(glob_o) && $stable(loc_o) && $stable(chsel_o)); // R9

  AST_LOC_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && chsel_o == '0) |=> $stable(loc_o)); // R5

  for (genvar l = 0; l < NUM_L; l++) begin : g_both
    AST_BOTH_SAME: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_i && addr_i == L_ADDR[l] && (&chsel_o))
        |=> loc_o[l*DATA_W +: DATA_W] == loc_o[(NUM_L+l)*DATA_W +: DATA_W]); // R3
  end
endmodule

bind cfg_bank cfg_bank_chk u_chk (.*);

// File: tb/cfg_bank_test.sv
module cfg_bank_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [8:0]  addr = '0;
  logic [7:0]  wdata = '0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [7:0]  rdata;
  logic        bad;
  logic [1:0]  chsel;
  logic [39:0] glob;
  logic [47:0] loc;

  int n_chk = 0, n_bad = 0;
  logic [7:0] m_g [5];
  logic [7:0] m_l [2][3];
  logic [1:0] m_idx;

  always #10 clk = ~clk;

  cfg_bank uut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wdata_i(wdata),
    .wr_i(wr), .rd_i(rd), .rdata_o(rdata), .bad_addr_o(bad),
    .chsel_o(chsel), .glob_o(glob), .loc_o(loc)
  );

  function automatic int g_slot(logic [8:0] a);
    case (a)
      9'h000: return 0; 9'h001: return 1; 9'h002: return 2;
      9'h014: return 3; 9'h100: return 4; default: return -1;
    endcase
  endfunction
  function automatic int l_slot(logic [8:0] a);
    case (a)
      9'h008: return 0; 9'h00D: return 1; 9'h102: return 2; default: return -1;
    endcase
  endfunction
  function automatic logic [7:0] g_mask(int i);
    case (i) 0: return 8'h7E; 1: return 8'hFF; 2: return 8'h0F; 3: return 8'hFF; default: return 8'h07; endcase
  endfunction
  function automatic logic [7:0] l_mask(int i);
    case (i) 0: return 8'hE3; 1: return 8'h3F; default: return 8'hFF; endcase
  endfunction
  function automatic logic ok_addr(logic [8:0] a);
    return (a == 9'h005) || g_slot(a) >= 0 || l_slot(a) >= 0;
  endfunction
  function automatic logic [7:0] exp_rd(logic [8:0] a);
    int s;
    if (a == 9'h005) return {6'b0, m_idx};
    s = g_slot(a);
    if (s >= 0) return m_g[s];
    s = l_slot(a);
    if (s >= 0) begin
      if (m_idx[0]) return m_l[0][s];
      if (m_idx[1]) return m_l[1][s];
    end
    return 8'h00;
  endfunction

  task automatic model_reset();
    m_g[0] = 8'h18; m_g[1] = 8'h00; m_g[2] = 8'h05; m_g[3] = 8'h01; m_g[4] = 8'h02;
    for (int c = 0; c < 2; c++) begin
      m_l[c][0] = 8'h00; m_l[c][1] = 8'h00; m_l[c][2] = 8'h80;
    end
    m_idx = 2'b11;
  endtask

  task automatic model_wr(logic [8:0] a, logic [7:0] d);
    int s;
    if (a == 9'h005) m_idx = d[1:0];
    s = g_slot(a);
    if (s >= 0) m_g[s] = d & g_mask(s);
    s = l_slot(a);
    if (s >= 0)
      for (int c = 0; c < 2; c++) if (m_idx[c]) m_l[c][s] = d & l_mask(s);
  endtask

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic chk_state(string tag);
    for (int g = 0; g < 5; g++) chk({tag, " R11 glob"}, 64'(glob[g*8 +: 8]), 64'(m_g[g]));
    for (int c = 0; c < 2; c++)
      for (int l = 0; l < 3; l++) chk({tag, " R11 loc"}, 64'(loc[(c*3+l)*8 +: 8]), 64'(m_l[c][l]));
    chk({tag, " R2 chsel"}, 64'(chsel), 64'(m_idx));
  endtask

  // starts and ends at a falling edge
  task automatic op(bit w, bit r, logic [8:0] a, logic [7:0] d, string tag);
    logic [7:0] e_rd, prev;
    logic e_bad;
    e_rd = exp_rd(a);
    prev = rdata;
    e_bad = (w | r) & ~ok_addr(a);
    addr = a; wdata = d; wr = w; rd = r;
    @(posedge clk);
    if (w) model_wr(a, d);
    @(negedge clk);
    wr = 1'b0; rd = 1'b0;
    chk({tag, r ? " rdata" : " R9 hold"}, 64'(rdata), 64'(r ? e_rd : prev));
    chk({tag, " R8 bad"}, 64'(bad), 64'(e_bad));
    chk_state(tag);
  endtask

  logic [8:0] pool [10] = '{9'h000, 9'h001, 9'h002, 9'h005, 9'h008,
                            9'h00D, 9'h014, 9'h100, 9'h102, 9'h003};
  bit done = 1'b0;

  initial begin
    void'($urandom(32'd2718));
    model_reset();
    #35 rst_n = 1'b1;
    @(negedge clk);
    chk("R1 rdata reset", 64'(rdata), 64'h0);
    chk("R1 bad reset", 64'(bad), 64'h0);
    chk_state("R1 reset");

    op(0, 1, 9'h005, 8'h00, "R2 idx read");
    chk("R2 idx default", 64'(rdata), 64'h03);
    op(1, 0, 9'h005, 8'hFF, "R7 idx wr");
    op(0, 1, 9'h005, 8'h00, "R7 idx upper zero");
    chk("R7 idx upper", 64'(rdata), 64'h03);

    op(1, 0, 9'h005, 8'h01, "R3 sel A");
    op(1, 0, 9'h008, 8'hFF, "R3 R7 wr A only");
    chk("R7 masked A", 64'(loc[7:0]), 64'hE3);
    op(1, 0, 9'h005, 8'h02, "R3 sel B");
    op(1, 0, 9'h008, 8'h5A, "R3 wr B only");
    chk("R3 B copy", 64'(loc[31:24]), 64'h42);
    op(0, 1, 9'h008, 8'h00, "R4 rd B");
    chk("R4 B read", 64'(rdata), 64'h42);
    op(1, 0, 9'h005, 8'h03, "R3 sel both");
    op(1, 0, 9'h00D, 8'h2C, "R3 wr both");
    op(0, 1, 9'h008, 8'h00, "R4 both reads A");
    chk("R4 both->A", 64'(rdata), 64'hE3);

    op(1, 0, 9'h005, 8'h00, "R5 sel none");
    op(1, 0, 9'h102, 8'h11, "R5 wr dropped");
    op(0, 1, 9'h102, 8'h00, "R5 rd zero");
    chk("R5 zero", 64'(rdata), 64'h00);
    op(1, 0, 9'h100, 8'hFE, "R6 R7 glob wr");
    chk("R6 glob", 64'(glob[39:32]), 64'h06);

    op(1, 1, 9'h003, 8'hAA, "R8 bad access");
    op(0, 0, 9'h000, 8'h00, "R8 bad drops");
    op(0, 1, 9'h1FF, 8'h00, "R8 bad read");

    op(1, 1, 9'h014, 8'h77, "R10 rd+wr");
    chk("R10 old value", 64'(rdata), 64'h01);

    for (int i = 0; i < 400; i++) begin
      logic [8:0] a;
      int k;
      a = ($urandom % 4 == 0) ? 9'($urandom) : pool[$urandom % 10];
      k = $urandom % 4;
      op(k == 0 || k == 2, k == 1 || k == 2, a, 8'($urandom), "rand R3 R4 R9");
    end
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int cyc = 0; cyc < 100000; cyc++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog R9 actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule